// File: doc/BRIEF.md
# Paged Program Counter Sequencer

This block produces the instruction fetch address for a small 4-bit microcontroller. The address inside a 64-word page is not held in a binary counter. It is held in a 6-bit feedback shift register, so successive fetches visit the page in a fixed scrambled order. The full ROM address joins a 2-bit chapter, a 4-bit page and the 6-bit offset.

Control transfers never carry a page or a chapter. A branch or call supplies only a 6-bit in-page target. The destination page and chapter come from two buffer registers:

- A "load page" strobe writes the page buffer.
- A "page-to-chapter" strobe copies the low bits of the page buffer into the chapter buffer.

Software therefore reaches another page by loading the page buffer before it branches. It reaches another chapter by loading a value, copying it into the chapter buffer, loading the page, and then branching or calling.

A single-level subroutine register keeps the return context. A return puts back the offset, page and chapter. It also realigns both buffers with the restored location.

Top module: `pc_seq`

## Requirements
- R1: While reset is high, and on the first clock after it, offset, page, chapter, page buffer, chapter buffer and saved context are all zero, so the address output is 0.
- R2: A step moves the offset to `{offset[4:0], f}`. Here f is the XNOR of offset bits 5 and 4, except that f is 1 when the offset is 0x1F and 0 when it is 0x3F. Starting from 0x00, steps give 0x01, 0x03, 0x07, 0x0F, 0x1F, 0x3F, 0x3E.
- R3: The address output is chapter×1024 + page×64 + offset, that is `{chapter[1:0], page[3:0], offset[5:0]}`. For example, chapter 0, page 6, offset 0x22 gives 0x1A2.
- R4: A load-page strobe writes its 4-bit value into the page buffer. A page-to-chapter strobe copies page buffer bits [1:0] into the chapter buffer. Neither strobe changes the address output.
- R5: A branch with the condition high sets page from the page buffer, chapter from the chapter buffer and offset from the target. A branch with the condition low only steps the offset, as in R2.
- R6: A taken branch leaves both buffers unchanged, so a second branch goes to the same page and chapter.
- R7: A call jumps like a taken branch. It also saves the stepped-next offset, the current page and the current chapter.
- R8: A return restores offset, page and chapter from the saved context. It also sets the page buffer to the restored page and the chapter buffer to the restored chapter.
- R9: A branch, taken or not, leaves the saved context unchanged. A later return therefore comes back to the point after the call.
- R10: When several transfer strobes arrive in one cycle, the priority is return, then call, then branch, then step. On a return cycle, the return's buffer update overrides load-page and page-to-chapter. With no strobe, the address holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_i | input | 1 | Advance the offset by one shift-register step |
| ld_pb_i | input | 1 | Write pb_val_i into the page buffer |
| pb_val_i | input | 4 | Value for the page buffer |
| pb_to_cb_i | input | 1 | Copy page buffer bits [1:0] into the chapter buffer |
| br_i | input | 1 | Branch request |
| br_cond_i | input | 1 | Branch condition; low turns the branch into a step |
| tgt_i | input | 6 | In-page target for branch and call |
| call_i | input | 1 | Subroutine call |
| ret_i | input | 1 | Subroutine return |
| rom_addr_o | output | 12 | Absolute ROM address {chapter, page, offset} |

## Verification
A wrong feedback tap or missing override shows as a wrong address on the very next clock after a step from the affected offset. Wrong buffer contents stay hidden until the next taken branch, call or return, when the upper address bits go wrong.

A corrupted saved context appears only at the return. The bench therefore checks the address on every clock against a behavioural model. It uses directed sequences in which a buffer fault or a context fault becomes visible within a few cycles.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
    parameter int OFF_W  = 6;
    parameter int PAGE_W = 4;
    parameter int CHAP_W = 2;
    localparam int ADDR_W = CHAP_W + PAGE_W + OFF_W;

    typedef logic [OFF_W-1:0]  off_t;
    typedef logic [PAGE_W-1:0] page_t;
    typedef logic [CHAP_W-1:0] chap_t;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_STEP,
        OP_BR,
        OP_CALL,
        OP_RET
    } op_e;

    typedef struct packed {
        off_t  off;
        page_t page;
        chap_t chap;
    } ret_ctx_t;

    localparam off_t OFF_ALL_ONES = '1;
    localparam off_t OFF_LOW_ONES = off_t'((1 << (OFF_W - 1)) - 1);

    function automatic off_t lfsr_step(input off_t cur);
        logic fb;
        if (cur == OFF_LOW_ONES)      fb = 1'b1;
        else if (cur == OFF_ALL_ONES) fb = 1'b0;
        else                          fb = ~(cur[OFF_W-1] ^ cur[OFF_W-2]);
        return {cur[OFF_W-2:0], fb};
    endfunction
endpackage

// File: rtl/pcs_offset.sv
module pcs_offset
    import pc_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    input  off_t tgt,
    input  off_t ret_off,
    output off_t off_q,
    output off_t off_nxt
);
    assign off_nxt = lfsr_step(off_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q <= '0;
        end else begin
            unique case (op)
                OP_STEP:       off_q <= off_nxt;
                OP_BR, OP_CALL: off_q <= tgt;
                OP_RET:        off_q <= ret_off;
                default:       off_q <= off_q;
            endcase
        end
    end

    // R2: the two forced feedback points
    a_r2_force_one: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP && off_q == OFF_LOW_ONES) |=> off_q == OFF_ALL_ONES);
    a_r2_force_zero: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP && off_q == OFF_ALL_ONES) |=> off_q == off_t'(OFF_ALL_ONES - 1));
    a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (op == OP_IDLE) |=> $stable(off_q));
endmodule

// File: rtl/pcs_page.sv
module pcs_page
    import pc_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op,
    input  logic  ld_pb,
    input  page_t pb_val,
    input  logic  pb_to_cb,
    input  page_t ret_page,
    input  chap_t ret_chap,
    output page_t page_q,
    output chap_t chap_q,
    output page_t pb_q,
    output chap_t cb_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            page_q <= '0;
            chap_q <= '0;
        end else begin
            unique case (op)
                OP_BR, OP_CALL: begin
                    page_q <= pb_q;
                    chap_q <= cb_q;
                end
                OP_RET: begin
                    page_q <= ret_page;
                    chap_q <= ret_chap;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pb_q <= '0;
            cb_q <= '0;
        end else if (op == OP_RET) begin
            pb_q <= ret_page;
            cb_q <= ret_chap;
        end else begin
            if (ld_pb)    pb_q <= pb_val;
            if (pb_to_cb) cb_q <= pb_q[CHAP_W-1:0];
        end
    end

    a_r6_br_keeps_buffers: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BR && !ld_pb && !pb_to_cb) |=> ($stable(pb_q) && $stable(cb_q)));
    a_r4_step_keeps_page: assert property (@(posedge clk) disable iff (rst)
        (op == OP_STEP || op == OP_IDLE) |=> ($stable(page_q) && $stable(chap_q)));
endmodule

// File: rtl/pcs_subr.sv
module pcs_subr
    import pc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  op_e      op,
    input  ret_ctx_t cur_ctx,
    output ret_ctx_t saved_q
);
    always_ff @(posedge clk) begin
        if (rst)               saved_q <= '0;
        else if (op == OP_CALL) saved_q <= cur_ctx;
    end

    // R9: branches never disturb the return context
    a_r9_br_keeps_ctx: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BR || op == OP_STEP) |=> $stable(saved_q));
endmodule

// File: rtl/pc_seq.sv
module pc_seq
    import pc_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step_i,
    input  logic              ld_pb_i,
    input  logic [PAGE_W-1:0] pb_val_i,
    input  logic              pb_to_cb_i,
    input  logic              br_i,
    input  logic              br_cond_i,
    input  logic [OFF_W-1:0]  tgt_i,
    input  logic              call_i,
    input  logic              ret_i,
    output logic [ADDR_W-1:0] rom_addr_o
);
    op_e      op;
    off_t     off_q, off_nxt;
    page_t    page_q, pb_q;
    chap_t    chap_q, cb_q;
    ret_ctx_t saved_q, cur_ctx;

    // R10: transfer priority
    always_comb begin
        if (ret_i)                  op = OP_RET;
        else if (call_i)            op = OP_CALL;
        else if (br_i && br_cond_i) op = OP_BR;
        else if (step_i || br_i)    op = OP_STEP;
        else                        op = OP_IDLE;
    end

    assign cur_ctx = '{off: off_nxt, page: page_q, chap: chap_q};

    pcs_offset u_off (
        .clk(clk), .rst(rst), .op(op), .tgt(tgt_i),
        .ret_off(saved_q.off), .off_q(off_q), .off_nxt(off_nxt)
    );

    pcs_page u_page (
        .clk(clk), .rst(rst), .op(op), .ld_pb(ld_pb_i), .pb_val(pb_val_i),
        .pb_to_cb(pb_to_cb_i), .ret_page(saved_q.page), .ret_chap(saved_q.chap),
        .page_q(page_q), .chap_q(chap_q), .pb_q(pb_q), .cb_q(cb_q)
    );

    pcs_subr u_subr (
        .clk(clk), .rst(rst), .op(op), .cur_ctx(cur_ctx), .saved_q(saved_q)
    );

    assign rom_addr_o = {chap_q, page_q, off_q};

    a_r1_reset_zero: assert property (@(posedge clk)
        $past(rst) |-> rom_addr_o == '0);
    a_r5_br_dest: assert property (@(posedge clk) disable iff (rst)
        (op == OP_BR) |=> (off_q == $past(tgt_i) && page_q == $past(pb_q)
                           && chap_q == $past(cb_q)));
    a_r8_ret_realign: assert property (@(posedge clk) disable iff (rst)
        (op == OP_RET) |=> (pb_q == page_q && cb_q == chap_q));
    a_r7_call_dest: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CALL) |=> (off_q == $past(tgt_i) && page_q == $past(pb_q)));
endmodule

// File: tb/sim_pc_seq.sv
module sim_pc_seq;
    logic        clk = 0;
    logic        rst = 1;
    logic        step_i = 0, ld_pb_i = 0, pb_to_cb_i = 0;
    logic        br_i = 0, br_cond_i = 0, call_i = 0, ret_i = 0;
    logic [3:0]  pb_val_i = 0;
    logic [5:0]  tgt_i = 0;
    logic [11:0] rom_addr_o;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    int m_off = 0, m_page = 0, m_chap = 0, m_pb = 0, m_cb = 0;
    int s_off = 0, s_page = 0, s_chap = 0;
    int unsigned lcg = 32'h1234_5678;

    always #2.5 clk = ~clk;

    pc_seq u0 (
        .clk(clk), .rst(rst), .step_i(step_i), .ld_pb_i(ld_pb_i),
        .pb_val_i(pb_val_i), .pb_to_cb_i(pb_to_cb_i), .br_i(br_i),
        .br_cond_i(br_cond_i), .tgt_i(tgt_i), .call_i(call_i),
        .ret_i(ret_i), .rom_addr_o(rom_addr_o)
    );

    function automatic int next_off(input int o);
        int f;
        if (o == 31)      f = 1;
        else if (o == 63) f = 0;
        else              f = (((o / 32) % 2) == ((o / 16) % 2)) ? 1 : 0;
        return ((o * 2) % 64) + f;
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%03h expected 0x%03h", tag, got, exp);
        end
    endtask

    task automatic model_update;
        int old_pb = m_pb;
        if (ret_i) begin
            m_off = s_off; m_page = s_page; m_chap = s_chap;
            m_pb = s_page; m_cb = s_chap;
        end else begin
            if (call_i) begin
                s_off = next_off(m_off); s_page = m_page; s_chap = m_chap;
                m_off = tgt_i; m_page = m_pb; m_chap = m_cb;
            end else if (br_i && br_cond_i) begin
                m_off = tgt_i; m_page = m_pb; m_chap = m_cb;
            end else if (step_i || br_i) begin
                m_off = next_off(m_off);
            end
            if (ld_pb_i)    m_pb = pb_val_i;
            if (pb_to_cb_i) m_cb = old_pb % 4;
        end
    endtask

    task automatic cyc(input bit s, input bit lp, input int pv, input bit p2c,
                       input bit b, input bit bc, input int t, input bit c,
                       input bit r, input string tag);
        step_i = s; ld_pb_i = lp; pb_val_i = pv[3:0]; pb_to_cb_i = p2c;
        br_i = b; br_cond_i = bc; tgt_i = t[5:0]; call_i = c; ret_i = r;
        @(posedge clk);
        model_update();
        @(negedge clk);
        check(tag, int'(rom_addr_o), m_chap * 1024 + m_page * 64 + m_off);
        {step_i, ld_pb_i, pb_to_cb_i, br_i, br_cond_i, call_i, ret_i} = '0;
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(posedge clk); @(negedge clk);
        check("R1 reset", int'(rom_addr_o), 0);
        // R2 step order
        cyc(1,0,0,0,0,0,0,0,0,"R2 step");
        check("R2 0x01", int'(rom_addr_o), 'h01);
        for (int i = 0; i < 4; i++) cyc(1,0,0,0,0,0,0,0,0,"R2 step");
        check("R2 0x1F", int'(rom_addr_o), 'h1F);
        cyc(1,0,0,0,0,0,0,0,0,"R2 step");
        check("R2 0x3F", int'(rom_addr_o), 'h3F);
        cyc(1,0,0,0,0,0,0,0,0,"R2 step");
        check("R2 0x3E", int'(rom_addr_o), 'h3E);
        // R4 buffer loads do not move the address
        cyc(0,1,6,0,0,0,0,0,0,"R4 ldpb");
        check("R4 hold", int'(rom_addr_o), 'h3E);
        // R5 not taken
        cyc(0,0,0,0,1,0,'h22,0,0,"R5 not taken");
        check("R5 not taken", int'(rom_addr_o), next_off('h3E));
        // R3 / R5 taken
        cyc(0,0,0,0,1,1,'h22,0,0,"R5 taken");
        check("R3 0x1A2", int'(rom_addr_o), 'h1A2);
        cyc(0,0,0,0,1,1,'h10,0,0,"R6 rebranch");
        check("R6 same page", int'(rom_addr_o), 'h190);
        // R7 cross-chapter call
        cyc(0,1,2,0,0,0,0,0,0,"R4 ldpb");
        cyc(0,0,0,1,0,0,0,0,0,"R4 pb2cb");
        cyc(0,1,5,0,0,0,0,0,0,"R4 ldpb");
        cyc(0,0,0,0,0,0,'h05,1,0,"R7 call");
        check("R7 call dest", int'(rom_addr_o), 'h945);
        cyc(0,0,0,0,1,1,'h0A,0,0,"R9 br in sub");
        check("R9 br in sub", int'(rom_addr_o), 'h94A);
        cyc(0,0,0,0,1,0,'h0A,0,0,"R9 br not taken in sub");
        cyc(0,0,0,0,0,0,0,0,1,"R8 ret");
        check("R8 ret addr", int'(rom_addr_o), 'h1A0);
        cyc(0,0,0,0,1,1,'h01,0,0,"R8 buffers realigned");
        check("R8 buffers realigned", int'(rom_addr_o), 'h181);
        // R10 priority and ret overriding buffer writes
        cyc(0,1,3,0,0,0,0,0,0,"R4 ldpb");
        cyc(0,0,0,0,0,0,'h07,1,0,"R7 call");
        cyc(1,1,9,1,1,1,'h11,1,1,"R10 ret wins");
        cyc(0,0,0,0,1,1,'h02,0,0,"R10 buffers from ret");
        cyc(0,0,0,0,0,0,0,0,0,"R10 idle hold");
        // mixed stream
        for (int i = 0; i < 400; i++) begin
            int k;
            lcg = lcg * 1103515245 + 12345;
            k = int'((lcg >> 16) % 16);
            case (k)
                0,1,2,3,4,5: cyc(1,0,0,0,0,0,0,0,0,"R2 mix step");
                6,7:   cyc(0,1,int'((lcg >> 8) % 16),0,0,0,0,0,0,"R4 mix ldpb");
                8:     cyc(0,0,0,1,0,0,0,0,0,"R4 mix pb2cb");
                9,10,11: cyc(0,0,0,0,1,k != 11,int'((lcg >> 4) % 64),0,0,"R5 mix br");
                12:    cyc(0,0,0,0,0,0,int'((lcg >> 4) % 64),1,0,"R7 mix call");
                13:    cyc(0,0,0,0,0,0,0,0,1,"R8 mix ret");
                14:    cyc(0,0,0,0,0,0,0,0,0,"R10 mix idle");
                default: cyc(1,1,int'((lcg >> 8) % 16),1,1,1,int'((lcg >> 4) % 64),
                             (lcg >> 3) % 2 == 1,0,"R10 mix combo");
            endcase
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule